// File: doc/BRIEF.md
# Strap-Sampled Mode Latch with External Interrupt Lines

This block serves three active-low input pins, called A, B and D, that do two jobs. While the chip reset is held, the pins are configuration straps. The last synchronized value seen before reset is released is kept as a 3-bit operating mode. The mode selects one of eight start-up modes and does not change again until the next reset.

After reset, the same pins become external interrupt request lines. Each line is re-timed to the system clock. Each line can be masked, and each can be set either to follow the pin level or to latch a falling edge into a sticky pending bit. A one-cycle acknowledge clears a sticky bit.

Two wake outputs let the core leave its low-power states. Any unmasked pending request ends a wait. Only line A can end a stop. A small write-only register port sets the mask and trigger-type bits.

Top module: `msirq_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pend`, `wake_wait` and `wake_stop` are 0. Reset leaves every line masked (mask bit 1) and level-triggered (trigger bit 0).
- R2: `op_mode` = {D, B, A} holds the logical pin levels (pin high gives 1) sampled at the last rising clock edge with `rst_n` low. The pins must be stable for at least two cycles before that edge. After release, `op_mode` does not change whatever the pins do.
- R3: For an unmasked level-triggered line, `pend[i]` is the inverse of the pin, two rising edges after the pin changes. `ack` has no effect on it.
- R4: For an unmasked edge-triggered line, a high-to-low pin transition sets `pend[i]` three rising edges after the pin falls. The bit stays 1 after the pin returns high.
- R5: A one-cycle `ack[i]` clears a sticky edge-mode bit at the next rising edge. If a new falling edge is detected at that same edge, the bit stays 1.
- R6: A masked line keeps `pend[i]` at 0. A falling edge that arrives while the line is masked is lost, and so is a bit that was pending when the line was masked: unmasking does not bring either back.
- R7: `wake_wait` is 1 exactly when any bit of `pend` is 1.
- R8: `wake_stop` is 1 exactly when `pend[0]` (line A) is 1. A request pending on B or D alone leaves it at 0.
- R9: A write with `cfg_we`=1 loads `cfg_wdata` (bit 0 = A, bit 1 = B, bit 2 = D) into the mask register when `cfg_sel`=0 (1 = masked), or into the trigger register when `cfg_sel`=1 (1 = falling edge, 0 = level). The new setting applies from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asynchronous clear of the control state |
| pin_n | input | 3 | Strap / interrupt pins, active-low, bit 0 = A, 1 = B, 2 = D |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target register: 0 = mask, 1 = trigger type |
| cfg_wdata | input | 3 | Write data, one bit per line |
| ack | input | 3 | One-cycle acknowledge per line |
| pend | output | 3 | Pending request per line |
| wake_wait | output | 1 | Ends the wait state |
| wake_stop | output | 1 | Ends the stop state (line A only) |
| op_mode | output | 3 | Latched operating mode {D, B, A} |

## Verification
A level-mode result is due two rising edges after the pin moves, because of the two synchronizer stages. An edge-mode result is due three rising edges after the pin falls, since it needs one more edge to register the pending bit. Acknowledges and configuration writes act at the first rising edge. The table walker drives each vector on a falling edge, waits three rising edges and samples on the next falling edge, so every kind of result has settled by the time it is checked. The race test places the acknowledge at exactly the third rising edge after the pin falls. The mode checks sample after the release edge and again after the pins have moved.

// File: rtl/msirq_pkg.sv
package msirq_pkg;

    localparam int unsigned LINE_COUNT = 3;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned STOP_LINE  = 0;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_TRIG = 1'b1
    } cfg_sel_e;

endpackage

// File: rtl/msirq_sync.sv
module msirq_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dout_prev
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    // Free-running: keeps sampling during reset so straps can be captured.
    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign dout      = s_q.chain[STAGES-1];
    assign dout_prev = s_q.prev;

endmodule

// File: rtl/msirq_cfg.sv
module msirq_cfg #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask,
    output logic [W-1:0] trig
);

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] trig;
    } cfg_st_t;

    cfg_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            if (sel == msirq_pkg::CFG_MASK) begin
                c_d.mask = wdata;
            end else begin
                c_d.trig = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.mask <= '1;
            c_q.trig <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mask = c_q.mask;
    assign trig = c_q.trig;

endmodule

// File: rtl/msirq_line.sv
module msirq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic mask,
    input  logic trig,
    input  logic ack,
    output logic req
);

    typedef struct packed {
        logic pend;
    } line_st_t;

    line_st_t l_d, l_q;
    logic     fall;
    logic     edge_mode;

    assign fall      = lvl_prev & ~lvl;
    assign edge_mode = (trig == msirq_pkg::TRIG_FALL);

    always_comb begin
        l_d = l_q;
        if (mask || !edge_mode) begin
            l_d.pend = 1'b0;
        end else if (fall) begin
            l_d.pend = 1'b1;
        end else if (ack) begin
            l_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    always_comb begin
        if (mask) begin
            req = 1'b0;
        end else if (edge_mode) begin
            req = l_q.pend;
        end else begin
            req = ~lvl;
        end
    end

endmodule

// File: rtl/msirq_mode.sv
module msirq_mode #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] straps,
    output logic [W-1:0] mode
);

    typedef struct packed {
        logic [W-1:0] mode;
    } mode_st_t;

    mode_st_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (!rst_n) begin
            m_d.mode = straps;
        end
    end

    // Sampled while reset is low; frozen from the first edge after release.
    always_ff @(posedge clk) begin
        m_q <= m_d;
    end

    assign mode = m_q.mode;

endmodule

// File: rtl/msirq_ctrl.sv
module msirq_ctrl #(
    parameter int unsigned N_LINES        = msirq_pkg::LINE_COUNT,
    parameter int unsigned SYNC_STAGES    = msirq_pkg::SYNC_DEPTH,
    parameter int unsigned STOP_WAKE_LINE = msirq_pkg::STOP_LINE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [N_LINES-1:0] cfg_wdata,
    input  logic [N_LINES-1:0] ack,
    output logic [N_LINES-1:0] pend,
    output logic               wake_wait,
    output logic               wake_stop,
    output logic [N_LINES-1:0] op_mode
);

    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] lvl_prev;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] trig_q;

    msirq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .din       (pin_n),
        .dout      (lvl),
        .dout_prev (lvl_prev)
    );

    msirq_cfg #(.W(N_LINES)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .mask  (mask_q),
        .trig  (trig_q)
    );

    msirq_mode #(.W(N_LINES)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .straps (lvl),
        .mode   (op_mode)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        msirq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl[i]),
            .lvl_prev (lvl_prev[i]),
            .mask     (mask_q[i]),
            .trig     (trig_q[i]),
            .ack      (ack[i]),
            .req      (pend[i])
        );
    end

    assign wake_wait = |pend;
    assign wake_stop = pend[STOP_WAKE_LINE];

endmodule

// File: rtl/msirq_chk.sv
module msirq_chk #(
    parameter int unsigned N         = 3,
    parameter int unsigned STOP_LINE = 0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] pend,
    input logic         wake_wait,
    input logic         wake_stop,
    input logic [N-1:0] op_mode,
    input logic [N-1:0] ack,
    input logic         cfg_we,
    input logic [N-1:0] mask,
    input logic [N-1:0] trig,
    input logic [N-1:0] lvl,
    input logic [N-1:0] lvl_prev
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0 && !wake_wait && !wake_stop));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(op_mode));

    p_wake_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> wake_wait);

    p_wake_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_wait |-> (|pend));

    p_stop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_stop |-> pend[STOP_LINE]);

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_mask_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mask[i] |-> !pend[i]);

        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && !mask[i] && pend[i] && !ack[i] && !cfg_we) |=> pend[i]);

        p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && !mask[i] && ack[i] && !cfg_we && !(lvl_prev[i] && !lvl[i]))
            |=> !pend[i]);

        if (i != STOP_LINE) begin : g_nostop
            p_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[i] && !pend[STOP_LINE]) |-> !wake_stop);
        end
    end

endmodule

bind msirq_ctrl msirq_chk #(.N(N_LINES), .STOP_LINE(STOP_WAKE_LINE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .wake_wait (wake_wait),
    .wake_stop (wake_stop),
    .op_mode   (op_mode),
    .ack       (ack),
    .cfg_we    (cfg_we),
    .mask      (mask_q),
    .trig      (trig_q),
    .lvl       (lvl),
    .lvl_prev  (lvl_prev)
);

// File: tb/msirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module msirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_n = 3'b101;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic [2:0] ack = 3'b000;
    logic [2:0] pend;
    logic       wake_wait;
    logic       wake_stop;
    logic [2:0] op_mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    msirq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ack       (ack),
        .pend      (pend),
        .wake_wait (wake_wait),
        .wake_stop (wake_stop),
        .op_mode   (op_mode)
    );

    typedef struct packed {
        logic [2:0] pin;
        logic [2:0] ak;
        logic       we;
        logic       sel;
        logic [2:0] wd;
        logic [2:0] ep;
        logic       ew;
        logic       es;
        logic [3:0] rq;
    } vec_t;

    // pin and ep written {D,B,A}; sel 0 = mask, 1 = trigger
    localparam vec_t VECS [0:20] = '{
        '{3'b111, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd1}, // R1 idle
        '{3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd6}, // R6 masked at reset
        '{3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd9}, // R9 unmask all
        '{3'b110, 3'b000, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, 1'b1, 4'd3}, // R3 A level low
        '{3'b110, 3'b001, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, 1'b1, 4'd3}, // R3 ack ignored
        '{3'b011, 3'b000, 1'b0, 1'b0, 3'b000, 3'b100, 1'b1, 1'b0, 4'd8}, // R8 D no stop wake
        '{3'b101, 3'b000, 1'b0, 1'b0, 3'b000, 3'b010, 1'b1, 1'b0, 4'd8}, // R8 B no stop wake
        '{3'b111, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd3}, // R3 follows release
        '{3'b111, 3'b000, 1'b1, 1'b1, 3'b111, 3'b000, 1'b0, 1'b0, 4'd9}, // R9 all edge mode
        '{3'b101, 3'b000, 1'b0, 1'b0, 3'b000, 3'b010, 1'b1, 1'b0, 4'd4}, // R4 B falls
        '{3'b111, 3'b000, 1'b0, 1'b0, 3'b000, 3'b010, 1'b1, 1'b0, 4'd4}, // R4 sticky
        '{3'b111, 3'b010, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd5}, // R5 ack clears
        '{3'b110, 3'b000, 1'b0, 1'b0, 3'b000, 3'b001, 1'b1, 1'b1, 4'd7}, // R7 A edge wakes
        '{3'b111, 3'b001, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd5}, // R5 ack A
        '{3'b111, 3'b000, 1'b1, 1'b0, 3'b100, 3'b000, 1'b0, 1'b0, 4'd9}, // R9 mask D
        '{3'b011, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd6}, // R6 masked edge
        '{3'b111, 3'b000, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd6}, // R6
        '{3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd6}, // R6 edge was lost
        '{3'b011, 3'b000, 1'b0, 1'b0, 3'b000, 3'b100, 1'b1, 1'b0, 4'd4}, // R4 D edge
        '{3'b111, 3'b000, 1'b1, 1'b0, 3'b100, 3'b000, 1'b0, 1'b0, 4'd6}, // R6 mask hides
        '{3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 4'd6}  // R6 not revived
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(logic sel, logic [2:0] wd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = wd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply(int idx, vec_t v);
        string tag;
        @(negedge clk);
        pin_n = v.pin; ack = v.ak; cfg_we = v.we; cfg_sel = v.sel; cfg_wdata = v.wd;
        @(negedge clk);
        ack = 3'b000; cfg_we = 1'b0;
        ticks(2);
        tag = $sformatf("R%0d vec %0d pend", v.rq, idx);
        check(tag, 32'(pend), 32'(v.ep));
        tag = $sformatf("R%0d vec %0d wake_wait", v.rq, idx);
        check(tag, 32'(wake_wait), 32'(v.ew));
        tag = $sformatf("R%0d vec %0d wake_stop", v.rq, idx);
        check(tag, 32'(wake_stop), 32'(v.es));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R2 first strap set: {D,B,A} = 101
        ticks(5);
        check("R1 pend in reset", 32'(pend), 32'd0);
        rst_n = 1'b1;
        pin_n = 3'b111;
        @(negedge clk);
        check("R1 pend after release", 32'(pend), 32'd0);
        check("R1 wake_wait after release", 32'(wake_wait), 32'd0);
        check("R2 mode latched 101", 32'(op_mode), 32'b101);

        for (int i = 0; i <= 20; i++) begin
            apply(i, VECS[i]);
        end
        check("R2 mode held after activity", 32'(op_mode), 32'b101);

        // R5 race: new edge at the same clock as the acknowledge
        @(negedge clk); pin_n = 3'b101;
        ticks(3);
        check("R4 B pending before race", 32'(pend), 32'b010);
        pin_n = 3'b111;
        ticks(2);
        pin_n = 3'b101;                 // falls before e1
        ticks(2);                       // after e2: fall seen
        ack = 3'b010;                   // lands on e3
        @(negedge clk); ack = 3'b000;
        check("R5 edge beats ack", 32'(pend), 32'b010);
        ack = 3'b010;                   // no new edge this time
        @(negedge clk); ack = 3'b000;
        check("R5 lone ack clears", 32'(pend), 32'b000);

        // R1 mid-run reset with D pending, new straps {D,B,A} = 010
        pin_n = 3'b111;
        ticks(2);
        pin_n = 3'b011;
        ticks(3);
        check("R4 D pending before reset", 32'(pend), 32'b100);
        #2 rst_n = 1'b0; pin_n = 3'b010;
        #1 check("R1 pend cleared by reset", 32'(pend), 32'd0);
        check("R1 wake_wait cleared by reset", 32'(wake_wait), 32'd0);
        ticks(5);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 mode latched 010", 32'(op_mode), 32'b010);
        pin_n = 3'b000;
        ticks(3);
        check("R2 mode unmoved by pins", 32'(op_mode), 32'b010);
        check("R1 default mask holds pend", 32'(pend), 32'd0);
        check("R1 default mask holds wake_stop", 32'(wake_stop), 32'd0);

        write_cfg(1'b0, 3'b000);        // R9 unmask
        ticks(1);
        check("R1 default level trigger", 32'(pend), 32'b111);
        check("R8 A wakes stop", 32'(wake_stop), 32'd1);
        write_cfg(1'b1, 3'b001);        // R9 A to edge mode, pin stays low
        ticks(1);
        check("R9 A edge mode no fall", 32'(pend), 32'b110);
        check("R8 B and D do not wake stop", 32'(wake_stop), 32'd0);
        check("R7 wake_wait from B and D", 32'(wake_wait), 32'd1);

        finish_run();
    end

endmodule